// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an eight-pin general-purpose I/O port through a small register bus. Each pin has a direction bit and an output latch bit. A pin whose direction bit is set drives its latch value onto the pad. A pin whose direction bit is clear leaves its driver off, so the pad floats. The pad is modelled as three separate signals: driven value, driver enable and sampled level. The system resolves the tri-state outside the block.

Reads of the data register return the pad level after a two-flop synchronizer, never the latch contents. Because of this, a pin used as an interrupt source can still be read as an ordinary input. The latch has no reset, so a value written before reset is still there afterwards. Software loads the latch and then turns on the direction bits.

A small driver-mode state machine handles standby. Its two states are `DRV_LIVE` and `DRV_FLOAT`:
- It moves from `DRV_LIVE` to `DRV_FLOAT` when the standby input and the pin-state select input are both high at a clock edge. In `DRV_FLOAT` every enable is held low.
- It moves from `DRV_FLOAT` back to `DRV_LIVE` at the first edge where either input is low. It then stays in `DRV_LIVE` until both are high again.
- Reset puts it in `DRV_LIVE`.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, and after it is released, every direction bit is 0 and `pad_oe` is all zeros. `rdata` is 0 after reset until the first read.
- R2: When direction bit i is 1 and the driver state is live, `pad_oe[i]` is 1. `pad_out` always shows the latch.
- R3: A write to offset 0 updates the latch (`pad_out`) at the next edge for every pin, in either direction. An input pin does not drive the new value until its direction bit is set.
- R4: A read of offset 0 returns the resolved pin level, not the latch. For example, an input pin driven externally against its latch bit reads the external level.
- R5: A pin level present at clock edge n is returned by a data read whose `rd_en` is sampled at edge n+2. A read sampled at edge n+1 still returns the older level.
- R6: Offset 1 holds the direction bits. A write stores `wdata`, and a read returns the stored bits.
- R7: Reset leaves the output latch unchanged.
- R8: When `standby` and `pin_hiz` are both 1 at an edge, `pad_oe` is all zeros from that edge on, whatever the direction bits are. Direction writes are still stored during this time.
- R9: `standby` alone, or `pin_hiz` alone, has no effect on `pad_oe`.
- R10: At the first edge where `standby` or `pin_hiz` is low, `pad_oe` follows the direction bits again. Neither the latch nor the direction bits are lost.
- R11: Offsets 2 and above are unmapped. Writes to them change nothing, and reads from them return 0.
- R12: `rdata` changes only at an edge where `rd_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid after the next edge |
| addr | input | 2 | Register offset: 0 = data, 1 = direction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| standby | input | 1 | Device is in stop or watch standby |
| pin_hiz | input | 1 | Pin-state select; when set, standby floats all pins |
| pad_in | input | 8 | Resolved pad levels |
| pad_out | output | 8 | Value offered to each pad driver |
| pad_oe | output | 8 | Per-pin driver enable |

## Verification
Two functions can fall in the same cycle: standby forcing the drivers off, and a bus write to the direction register. The bench rewrites the direction register while `standby` and `pin_hiz` are both high. The rewrite is judged correct when three things hold:
- `pad_oe` stays all zeros while the force is on.
- Reading offset 1 returns the new bits, and a data read returns the external levels of the floating pins.
- `pad_oe` takes on the new bits exactly one edge after the force is released.

Random rounds also toggle `standby` and `pin_hiz` in the same cycles as the data and direction writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic {
        DRV_LIVE  = 1'b0,
        DRV_FLOAT = 1'b1
    } drv_state_t;

    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_DIR  = 1;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  latch_q
);
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);

    // direction bits: cleared by reset
    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= '0;
        else if (wr_en && addr == A_DIR)
            dir_q <= wdata;
    end

    // output latch: deliberately without reset
    always_ff @(posedge clk) begin
        if (wr_en && addr == A_DATA)
            latch_q <= wdata;
    end
endmodule

// File: rtl/gpio_drive_fsm.sv
module gpio_drive_fsm
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         standby_i,
    input  logic         hiz_sel_i,
    input  logic [W-1:0] dir_i,
    output logic [W-1:0] oe_o
);
    drv_state_t state_q, state_d;
    logic       force_off;

    assign force_off = standby_i && hiz_sel_i;

    always_ff @(posedge clk) begin
        if (rst) state_q <= DRV_LIVE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRV_LIVE:  if (force_off)  state_d = DRV_FLOAT;
            DRV_FLOAT: if (!force_off) state_d = DRV_LIVE;
            default:                   state_d = DRV_LIVE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            DRV_LIVE:  oe_o = dir_i;
            DRV_FLOAT: oe_o = '0;
            default:   oe_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          standby,
    input  logic          pin_hiz,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    localparam int SYNC_STAGES = 2;

    logic [W-1:0] dir_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] rd_mux;

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .latch_q(latch_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .d  (pad_in),
        .q  (pin_sync)
    );

    gpio_drive_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .standby_i(standby),
        .hiz_sel_i(pin_hiz),
        .dir_i    (dir_q),
        .oe_o     (pad_oe)
    );

    assign pad_out = latch_q;

    always_comb begin
        if (addr == AW'(OFS_DATA))      rd_mux = pin_sync;
        else if (addr == AW'(OFS_DIR))  rd_mux = dir_q;
        else                            rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  rdata,
    input logic          standby,
    input logic          pin_hiz,
    input logic [W-1:0]  pad_in,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  dir_q
);
    // R1
    reset_oe_off_chk: assert property (@(posedge clk)
        $past(rst) |-> pad_oe == '0);

    // R3
    data_write_chk: assert property (@(posedge clk)
        $past(wr_en && addr == AW'(0)) |-> pad_out == $past(wdata));

    // R5
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && addr == AW'(0)) && !$past(rst)) |-> rdata == $past(pad_in, 3));

    // R8
    standby_float_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(standby && pin_hiz) && !$past(rst)) |-> pad_oe == '0);

    // R10
    live_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(standby && pin_hiz) && !$past(rst)) |-> pad_oe == dir_q);

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && addr > AW'(1)) && !$past(rst)) |-> rdata == '0);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_en) && !$past(rst)) |-> $stable(rdata));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .standby(standby),
    .pin_hiz(pin_hiz),
    .pad_in (pad_in),
    .pad_out(pad_out),
    .pad_oe (pad_oe),
    .dir_q  (dir_q)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       standby = 1'b0, pin_hiz = 1'b0;
    logic [7:0] ext = '0;
    logic [7:0] pad_in, pad_out, pad_oe;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .standby(standby), .pin_hiz(pin_hiz),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] pin_level(logic [7:0] oe, logic [7:0] drv, logic [7:0] e);
        return (oe & drv) | (~oe & e);
    endfunction

    function automatic logic [7:0] oe_model(logic [7:0] dir, logic sb, logic hz);
        return (sb && hz) ? 8'h00 : dir;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v, dir_m, lat_m;
        void'($urandom(32'h5eed_1234));

        repeat (4) @(negedge clk);
        chk("R1 oe in reset", pad_oe, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 8'h00);
        chk("R1 oe after reset", pad_oe, 8'h00);
        bus_rd(2'd1, v); chk("R1 R6 dir after reset", v, 8'h00);

        // input mode: latch written but not driven
        ext = 8'h3C;
        bus_wr(2'd0, 8'hA5);
        chk("R3 latch updated", pad_out, 8'hA5);
        chk("R3 not driven", pad_oe, 8'h00);
        settle(); bus_rd(2'd0, v); chk("R4 reads pin not latch", v, 8'h3C);

        // full output
        bus_wr(2'd1, 8'hFF);
        chk("R2 oe follows dir", pad_oe, 8'hFF);
        bus_rd(2'd1, v); chk("R6 dir readback", v, 8'hFF);
        settle(); bus_rd(2'd0, v); chk("R4 output pin read", v, 8'hA5);

        // mixed
        ext = 8'hF0;
        bus_wr(2'd1, 8'h0F);
        settle(); bus_rd(2'd0, v); chk("R4 mixed pins", v, pin_level(8'h0F, 8'hA5, 8'hF0));

        // synchronizer latency
        bus_wr(2'd1, 8'h00); ext = 8'h00; settle();
        @(negedge clk); ext = 8'hFF; rd_en = 1'b1; addr = 2'd0;
        @(negedge clk); chk("R5 edge n", rdata, 8'h00);
        @(negedge clk); chk("R5 edge n+1", rdata, 8'h00);
        @(negedge clk); chk("R5 edge n+2", rdata, 8'hFF);
        rd_en = 1'b0;

        // rdata hold
        ext = 8'h11; settle(); chk("R12 rdata held", rdata, 8'hFF);

        // unmapped
        bus_wr(2'd2, 8'h55);
        chk("R11 latch kept", pad_out, 8'hA5);
        bus_rd(2'd1, v); chk("R11 dir kept", v, 8'h00);
        bus_rd(2'd3, v); chk("R11 unmapped read", v, 8'h00);

        // latch survives reset
        bus_wr(2'd0, 8'h3C); bus_wr(2'd1, 8'hFF);
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after second reset", pad_oe, 8'h00);
        chk("R7 latch survives", pad_out, 8'h3C);
        bus_wr(2'd1, 8'hFF); settle(); bus_rd(2'd0, v); chk("R7 latch driven", v, 8'h3C);

        // standby force and concurrent direction write
        ext = 8'h96;
        @(negedge clk); standby = 1'b1; pin_hiz = 1'b1;
        chk("R8 before edge", pad_oe, 8'hFF);
        @(negedge clk); chk("R8 forced off", pad_oe, 8'h00);
        bus_wr(2'd1, 8'h0F);
        chk("R8 still off after dir write", pad_oe, 8'h00);
        bus_rd(2'd1, v); chk("R8 dir stored", v, 8'h0F);
        settle(); bus_rd(2'd0, v); chk("R8 pins float", v, 8'h96);
        @(negedge clk); standby = 1'b0; pin_hiz = 1'b0;
        chk("R10 before edge", pad_oe, 8'h00);
        @(negedge clk); chk("R10 follows dir", pad_oe, 8'h0F);
        chk("R10 latch kept", pad_out, 8'h3C);

        // single condition has no effect
        @(negedge clk); standby = 1'b1;
        repeat (2) @(negedge clk); chk("R9 standby alone", pad_oe, 8'h0F);
        standby = 1'b0; pin_hiz = 1'b1;
        repeat (2) @(negedge clk); chk("R9 pin_hiz alone", pad_oe, 8'h0F);
        pin_hiz = 1'b0;

        // random rounds
        dir_m = 8'h0F; lat_m = 8'h3C;
        for (int i = 0; i < 40; i++) begin
            lat_m = 8'($urandom); dir_m = 8'($urandom);
            bus_wr(2'd0, lat_m);
            @(negedge clk);
            wr_en = 1'b1; addr = 2'd1; wdata = dir_m;
            standby = 1'($urandom); pin_hiz = 1'($urandom); ext = 8'($urandom);
            @(negedge clk); wr_en = 1'b0;
            chk("R8 R10 random oe", pad_oe, oe_model(dir_m, standby, pin_hiz));
            chk("R3 random latch", pad_out, lat_m);
            settle(); bus_rd(2'd0, v);
            chk("R4 random pin", v, pin_level(oe_model(dir_m, standby, pin_hiz), lat_m, ext));
            bus_rd(2'd1, v); chk("R6 random dir", v, dir_m);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule